// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address by reading a three-level translation table held in memory. Pages are 16 KB. The block picks one of two table roots from the sign half of the address: a user root for low addresses and a kernel root for high addresses. It then reads one 8-byte descriptor per level over a simple request/response memory port. The walk stops early when it meets an invalid descriptor.

A successful walk returns the physical address together with the permission group and memory-attribute index stored in the leaf descriptor. A failed walk returns a translation fault and the address that caused it. A client offers one address at a time with a valid/ready handshake. The result is held until the client takes it. Caching of translations and the meaning of the returned group and attribute fields belong to other blocks.

Top module: `ptw_walker`

## Requirements
- R1: The read at level L targets the table base plus eight times that level's index. The level-1 index is VA[45:36] (10 bits), the level-2 index is VA[35:25] (11 bits) and the level-3 index is VA[24:14] (11 bits).
- R2: When VA[63] is 0 the first read uses `user_root`. When VA[63] is 1 it uses `kern_root`.
- R3: Reads are issued in level order 1, 2, 3. Descriptor bit 0 is the valid bit. The table base for the next level is descriptor bits [47:14] followed by 14 zero bits, and every other descriptor bit is ignored.
- R4: After a valid level-3 descriptor the result carries fault=0 and `res_pa` = {leaf[47:14], VA[13:0]}. It also carries `res_group` = leaf[61:58] and `res_attr` = leaf[4:2].
- R5: A descriptor with bit 0 clear at any level ends the walk with no further read. The result then has fault=1, `res_pa`, `res_group` and `res_attr` all zero, and `res_va` equal to the requested address. `res_va` always echoes the requested address.
- R6: An address whose bits [63:46] are neither all zeros nor all ones faults with no memory read. Its result is valid in the cycle after acceptance.
- R7: `req_ready` is 1 only when idle. From acceptance until the result is taken, further requests are ignored and leave the result unchanged.
- R8: `res_valid` and all result fields stay unchanged until a cycle with `res_ready` high. After that cycle `res_valid` drops and `req_ready` rises.
- R9: `mem_req_valid` is high for exactly one cycle per read. The next read is not issued until the response to the previous one arrives. A walk of n reads, each answered k cycles after the cycle following its request, shows `res_valid` n*(2+k)+1 cycles after acceptance.
- R10: After reset `req_ready` is 1 and `res_valid` and `mem_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to accept |
| req_va | input | 64 | Virtual address to translate |
| user_root | input | 48 | Table root for the low address half |
| kern_root | input | 48 | Table root for the high address half |
| mem_req_valid | output | 1 | Descriptor read request (one-cycle pulse) |
| mem_req_addr | output | 48 | Byte address of the descriptor |
| mem_rsp_valid | input | 1 | Descriptor data returned |
| mem_rsp_data | input | 64 | Descriptor contents |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Client takes the result |
| res_fault | output | 1 | Translation fault |
| res_pa | output | 48 | Physical address |
| res_group | output | 4 | Permission group from the leaf |
| res_attr | output | 3 | Memory-attribute index from the leaf |
| res_va | output | 64 | Address of the walk (faulting address on a fault) |

## Verification
Each read costs two cycles plus the memory's extra latency. The result of an n-read walk is therefore due n*(2+k)+1 cycles after the accepting edge, and a non-canonical address is answered one cycle after it. The bench counts falling edges from acceptance and compares the cycle in which `res_valid` first appears with that figure. It checks on every one of those cycles that `req_ready` stays low and that each read address matches the next entry of a behaviourally computed queue. Result fields are sampled away from the clock edge, both on arrival and across hold cycles, before `res_ready` releases them.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W        = 64;
    localparam int PA_W        = 48;
    localparam int DESC_W      = 64;
    localparam int OFF_W       = 14;
    localparam int LEVELS      = 3;
    localparam int TOP_IDX_W   = 10;
    localparam int LOW_IDX_W   = 11;
    localparam int IDX_MAX_W   = LOW_IDX_W;
    localparam int ENTRY_SHIFT = 3;
    localparam int GRP_W       = 4;
    localparam int GRP_LO      = 58;
    localparam int ATTR_W      = 3;
    localparam int ATTR_LO     = 2;
    localparam int USED_VA_W   = OFF_W + TOP_IDX_W + (LEVELS - 1) * LOW_IDX_W;
    localparam int SIGN_W      = VA_W - USED_VA_W;
    localparam int FRAME_W     = PA_W - OFF_W;

    typedef logic [1:0] level_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } walk_state_e;

    typedef struct packed {
        logic              fault;
        logic [PA_W-1:0]   pa;
        logic [GRP_W-1:0]  grp;
        logic [ATTR_W-1:0] attr;
    } walk_res_t;

    function automatic int idx_width(input int lvl);
        return (lvl == 0) ? TOP_IDX_W : LOW_IDX_W;
    endfunction

    function automatic int idx_low(input int lvl);
        int lo;
        lo = OFF_W;
        for (int k = LEVELS - 1; k > lvl; k--) begin
            lo = lo + idx_width(k);
        end
        return lo;
    endfunction

    function automatic logic [PA_W-1:0] next_base(input logic [DESC_W-1:0] d);
        return {d[PA_W-1:OFF_W], {OFF_W{1'b0}}};
    endfunction

endpackage

// File: rtl/ptw_root_sel.sv
module ptw_root_sel
    import ptw_pkg::*;
(
    input  logic [SIGN_W-1:0] va_sign,
    input  logic [PA_W-1:0]   user_root,
    input  logic [PA_W-1:0]   kern_root,
    output logic              canonical,
    output logic [PA_W-1:0]   root
);

    always_comb begin
        canonical = (&va_sign) | ~(|va_sign);
        root      = va_sign[SIGN_W-1] ? kern_root : user_root;
    end

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic [PA_W-1:0]            base,
    input  logic [USED_VA_W-1:OFF_W]   va_idx,
    input  level_t                     lvl,
    output logic [PA_W-1:0]            addr
);

    logic [IDX_MAX_W-1:0] idx_all [LEVELS];
    logic [IDX_MAX_W-1:0] sel;

    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        localparam int W  = idx_width(g);
        localparam int LO = idx_low(g);
        assign idx_all[g] = IDX_MAX_W'(va_idx[LO +: W]);
    end

    always_comb begin
        sel = idx_all[LEVELS-1];
        for (int k = 0; k < LEVELS; k++) begin
            if (lvl == level_t'(k)) sel = idx_all[k];
        end
        addr = base + (PA_W'(sel) << ENTRY_SHIFT);
    end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_va,
    input  logic [PA_W-1:0]   user_root,
    input  logic [PA_W-1:0]   kern_root,
    output logic              mem_req_valid,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DESC_W-1:0] mem_rsp_data,
    output logic              res_valid,
    input  logic              res_ready,
    output logic              res_fault,
    output logic [PA_W-1:0]   res_pa,
    output logic [GRP_W-1:0]  res_group,
    output logic [ATTR_W-1:0] res_attr,
    output logic [VA_W-1:0]   res_va
);

    walk_state_e     state;
    logic [VA_W-1:0] va_q;
    logic [PA_W-1:0] base_q;
    level_t          lvl_q;
    walk_res_t       res_q;

    logic            canonical;
    logic [PA_W-1:0] root;
    logic [PA_W-1:0] rd_addr;
    logic            unused_desc_bits;

    ptw_root_sel i_root_sel (
        .va_sign   (req_va[VA_W-1 -: SIGN_W]),
        .user_root (user_root),
        .kern_root (kern_root),
        .canonical (canonical),
        .root      (root)
    );

    ptw_addr_gen i_addr_gen (
        .base   (base_q),
        .va_idx (va_q[USED_VA_W-1:OFF_W]),
        .lvl    (lvl_q),
        .addr   (rd_addr)
    );

    assign unused_desc_bits = ^{mem_rsp_data[DESC_W-1:GRP_LO+GRP_W],
                                mem_rsp_data[GRP_LO-1:PA_W],
                                mem_rsp_data[OFF_W-1:ATTR_LO+ATTR_W],
                                mem_rsp_data[ATTR_LO-1:1]};

    always_comb begin
        req_ready     = (state == ST_IDLE);
        mem_req_valid = (state == ST_ISSUE);
        mem_req_addr  = rd_addr;
        res_valid     = (state == ST_DONE);
        res_fault     = res_q.fault;
        res_pa        = res_q.pa;
        res_group     = res_q.grp;
        res_attr      = res_q.attr;
        res_va        = va_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            va_q   <= '0;
            base_q <= '0;
            lvl_q  <= '0;
            res_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q   <= req_va;
                        base_q <= root;
                        lvl_q  <= '0;
                        if (canonical) begin
                            state <= ST_ISSUE;
                        end else begin
                            res_q       <= '0;
                            res_q.fault <= 1'b1;
                            state       <= ST_DONE;
                        end
                    end
                end
                ST_ISSUE: state <= ST_WAIT;
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!mem_rsp_data[0]) begin
                            res_q       <= '0;
                            res_q.fault <= 1'b1;
                            state       <= ST_DONE;
                        end else if (lvl_q == level_t'(LEVELS - 1)) begin
                            res_q.fault <= 1'b0;
                            res_q.pa    <= {mem_rsp_data[PA_W-1:OFF_W], va_q[OFF_W-1:0]};
                            res_q.grp   <= mem_rsp_data[GRP_LO +: GRP_W];
                            res_q.attr  <= mem_rsp_data[ATTR_LO +: ATTR_W];
                            state       <= ST_DONE;
                        end else begin
                            base_q <= next_base(mem_rsp_data);
                            lvl_q  <= level_t'(lvl_q + 2'd1);
                            state  <= ST_ISSUE;
                        end
                    end
                end
                ST_DONE: begin
                    if (res_ready) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R6: a non-canonical address is answered next cycle with a fault and no read
    a_r6_noncanon_fault: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !canonical) |=> (res_valid && res_fault && !mem_req_valid));

    // R5: an invalid descriptor ends the walk at once
    a_r5_invalid_ends: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && mem_rsp_valid && !mem_rsp_data[0]) |=> (res_valid && res_fault));

    // R7: no second acceptance right after a first
    a_r7_single_walk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R8: result held until taken
    a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_pa) && $stable(res_fault)
                                       && $stable(res_group) && $stable(res_attr) && $stable(res_va)));

    // R9: each read request is a single-cycle pulse
    a_r9_req_pulse: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |=> !mem_req_valid);

    // R3: level never runs past the leaf
    a_r3_level_range: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (lvl_q <= level_t'(LEVELS - 1)));

endmodule

// File: tb/test_ptw_walker.sv
module test_ptw_walker;
    import ptw_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst;
    logic              req_valid;
    logic              req_ready;
    logic [63:0]       req_va;
    logic [47:0]       user_root;
    logic [47:0]       kern_root;
    logic              mem_req_valid;
    logic [47:0]       mem_req_addr;
    logic              mem_rsp_valid;
    logic [63:0]       mem_rsp_data;
    logic              res_valid;
    logic              res_ready;
    logic              res_fault;
    logic [47:0]       res_pa;
    logic [3:0]        res_group;
    logic [2:0]        res_attr;
    logic [63:0]       res_va;

    int n_chk  = 0;
    int n_fail = 0;

    logic [63:0] mem [logic [47:0]];
    logic [47:0] exp_reads [$];
    logic [47:0] next_tbl;

    int          lat_cfg;
    bit          pending;
    int          wait_cnt;
    logic [47:0] pend_addr;

    logic        exp_fault;
    logic [47:0] exp_pa;
    logic [3:0]  exp_grp;
    logic [2:0]  exp_attr;
    int          exp_n;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ptw_walker i_ptw_walker (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
        .user_root(user_root), .kern_root(kern_root),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .res_valid(res_valid), .res_ready(res_ready), .res_fault(res_fault),
        .res_pa(res_pa), .res_group(res_group), .res_attr(res_attr), .res_va(res_va)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory model: answers each read lat_cfg cycles after the cycle that follows it
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (pending) begin
            if (wait_cnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem.exists(pend_addr) ? mem[pend_addr] : 64'h0;
                pending       = 1'b0;
            end else begin
                wait_cnt--;
            end
        end
        if (!rst && mem_req_valid) begin
            if (exp_reads.size() == 0) begin
                chk(1'b0, "R5 unexpected read", 64'(mem_req_addr), 64'h0);
            end else begin
                logic [47:0] e;
                e = exp_reads.pop_front();
                chk(mem_req_addr == e, "R1/R2/R3 read address", 64'(mem_req_addr), 64'(e));
            end
            pending   = 1'b1;
            wait_cnt  = lat_cfg;
            pend_addr = mem_req_addr;
        end
    end

    function automatic logic [47:0] lvl_addr(input logic [47:0] base, input logic [63:0] va, input int lvl);
        int shift;
        logic [63:0] mask;
        shift = 14 + 11 * (2 - lvl);
        mask  = (lvl == 0) ? 64'h3FF : 64'h7FF;
        return base + 48'(((va >> shift) & mask) * 8);
    endfunction

    // build tables; the entry at stop_lvl is left invalid (3 = complete mapping)
    task automatic map_page(input logic [63:0] va, input logic [47:0] frame, input logic [3:0] g,
                            input logic [2:0] a, input int stop_lvl);
        logic [47:0] base;
        logic [47:0] ad;
        base = va[63] ? kern_root : user_root;
        for (int lvl = 0; lvl < 3; lvl++) begin
            ad = lvl_addr(base, va, lvl);
            if (lvl == stop_lvl) begin
                mem[ad] = 64'h4000_0000_0000_C002;
                return;
            end
            if (lvl < 2) begin
                if (!mem.exists(ad) || !mem[ad][0]) begin
                    mem[ad] = 64'h0004_0000_0000_0003 | 64'(next_tbl);
                    next_tbl = next_tbl + 48'h4000;
                end
                base = mem[ad][47:0] & 48'hFFFF_FFFF_C000;
            end else begin
                mem[ad] = (64'(frame) & 64'h0000_FFFF_FFFF_C000) | (64'(g) << 58) | (64'(a) << 2)
                        | 64'h8000_0000_0000_0003 | 64'h0000_0000_0000_1F00;
            end
        end
    endtask

    task automatic build_expect(input logic [63:0] va);
        logic [17:0] sgn;
        logic [47:0] base;
        logic [47:0] ad;
        logic [63:0] d;
        exp_fault = 1'b0; exp_pa = '0; exp_grp = '0; exp_attr = '0; exp_n = 0;
        exp_reads.delete();
        sgn = va[63:46];
        if (sgn != 18'h0 && sgn != 18'h3FFFF) begin
            exp_fault = 1'b1;
            return;
        end
        base = va[63] ? kern_root : user_root;
        for (int lvl = 0; lvl < 3; lvl++) begin
            ad = lvl_addr(base, va, lvl);
            exp_reads.push_back(ad);
            exp_n++;
            d = mem.exists(ad) ? mem[ad] : 64'h0;
            if (!d[0]) begin
                exp_fault = 1'b1;
                return;
            end
            if (lvl < 2) begin
                base = d[47:0] & 48'hFFFF_FFFF_C000;
            end else begin
                exp_pa   = (d[47:0] & 48'hFFFF_FFFF_C000) | 48'(va[13:0]);
                exp_grp  = d[61:58];
                exp_attr = d[4:2];
            end
        end
    endtask

    task automatic run_walk(input logic [63:0] va, input int lat, input int hold, input string nm);
        int cyc;
        int exp_cyc;
        logic [47:0] pa_s;
        build_expect(va);
        lat_cfg = lat;
        exp_cyc = exp_n * (2 + lat) + 1;
        @(negedge clk);
        chk(req_ready == 1'b1, {"R7 ready before ", nm}, 64'(req_ready), 64'h1);
        req_va    = va;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_va = 64'hDEAD_0000_0000_0000;   // stray request kept up while busy
        cyc = 1;
        while (!res_valid && cyc < 2000) begin
            chk(req_ready == 1'b0, {"R7 ready low during ", nm}, 64'(req_ready), 64'h0);
            @(negedge clk);
            cyc++;
        end
        chk(cyc == exp_cyc, {"R9 result cycle ", nm}, 64'(cyc), 64'(exp_cyc));
        chk(req_ready == 1'b0, {"R7 ready low at result ", nm}, 64'(req_ready), 64'h0);
        chk(res_fault == exp_fault, {"R5/R6 fault ", nm}, 64'(res_fault), 64'(exp_fault));
        chk(res_pa == exp_pa, {"R4 pa ", nm}, 64'(res_pa), 64'(exp_pa));
        chk(res_group == exp_grp, {"R4 group ", nm}, 64'(res_group), 64'(exp_grp));
        chk(res_attr == exp_attr, {"R4 attr ", nm}, 64'(res_attr), 64'(exp_attr));
        chk(res_va == va, {"R5 va ", nm}, res_va, va);
        chk(exp_reads.size() == 0, {"R3/R5 read count ", nm}, 64'(exp_reads.size()), 64'h0);
        req_valid = 1'b0;
        pa_s = res_pa;
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(res_valid == 1'b1 && res_pa == pa_s && res_va == va, {"R8 hold ", nm},
                64'(res_pa), 64'(pa_s));
        end
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        chk(res_valid == 1'b0, {"R8 release ", nm}, 64'(res_valid), 64'h0);
        chk(req_ready == 1'b1, {"R8 ready after take ", nm}, 64'(req_ready), 64'h1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_va = '0; res_ready = 1'b0;
        mem_rsp_valid = 1'b0; mem_rsp_data = '0; pending = 1'b0; wait_cnt = 0; lat_cfg = 0;
        user_root = 48'h0000_1000_0000;
        kern_root = 48'h0000_2000_0000;
        next_tbl  = 48'h0000_4000_0000;

        map_page(64'h0000_1234_5678_9ABC, 48'h0ABC_DEF0_4000, 4'h9, 3'h5, 3);
        map_page(64'hFFFF_C012_3456_7DEF, 48'h0000_7777_8000, 4'h4, 3'h2, 3);
        map_page(64'h0000_3FFF_FFFF_FFFF, 48'hFFFF_FFFF_C000, 4'hF, 3'h7, 3);
        map_page(64'h0000_0800_0000_0000, 48'h0, 4'h0, 3'h0, 0);
        map_page(64'h0000_2000_0010_0000, 48'h0, 4'h0, 3'h0, 1);
        map_page(64'hFFFF_C000_0000_4000, 48'h0, 4'h0, 3'h0, 2);

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        chk(req_ready == 1'b1, "R10 req_ready", 64'(req_ready), 64'h1);
        chk(res_valid == 1'b0, "R10 res_valid", 64'(res_valid), 64'h0);
        chk(mem_req_valid == 1'b0, "R10 mem_req_valid", 64'(mem_req_valid), 64'h0);

        run_walk(64'h0000_1234_5678_9ABC, 0, 2, "R2 user half");
        run_walk(64'hFFFF_C012_3456_7DEF, 3, 0, "R2 kernel half");
        run_walk(64'h0000_3FFF_FFFF_FFFF, 1, 1, "R1 max indices");
        run_walk(64'h0000_0800_0000_0000, 0, 1, "R5 level1 invalid");
        run_walk(64'h0000_2000_0010_0000, 2, 0, "R5 level2 invalid");
        run_walk(64'hFFFF_C000_0000_4000, 0, 3, "R5 level3 invalid");
        run_walk(64'h0001_0000_0000_0000, 0, 1, "R6 noncanonical upper");
        run_walk(64'h8000_0000_0000_0000, 0, 0, "R6 noncanonical sign");
        run_walk(64'h0000_4000_0000_0000, 0, 0, "R6 noncanonical bit46");
        run_walk(64'h0000_1234_5678_9ABC, 2, 1, "R9 repeat with latency");

        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule